// File: doc/BRIEF.md
# Sector Erase Batch Window

This block collects several sector-erase requests into one erase batch before any erasure begins. An upstream command decoder has already checked the unlock cycles. It presents each decoded command for one cycle with a kind code and, for sector erase, a sector number. The first valid sector-erase request opens a timed window and marks its sector in a bitmap. Each later sector-erase request inside the window adds its sector and restarts the timer. When a full window passes with no new sector request, the block hands the bitmap to the erase engine with a one-cycle start pulse. It then reports busy until the engine signals completion.

While the window is open, any command that is neither sector erase nor erase suspend cancels the batch, clears the bitmap and returns the block to idle. An erase suspend is passed on to the suspend logic and leaves the batch untouched. A status bit tells the host whether the window is still open (0) or erasure has begun (1). The window length is a cycle-count parameter sized to 50 µs at the design clock, which is 10000 cycles at 200 MHz.

Top module: `sector_erase_batcher`

## Requirements
- R1: After reset, `win_open`, `erase_busy`, `erase_start`, `abort_pulse` and `suspend_fwd` are 0 and `erase_map` is all zeros.
- R2: In idle, a valid command of kind 2'b00 (sector erase) with a sector number below NUM_SECT opens the window. From the next cycle `win_open` is 1 and `erase_map` has only bit `cmd_sector` set.
- R3: While the window is open, further sector-erase commands set their bit in `erase_map` in any order. A sector that is already marked leaves the map unchanged. Bits are never cleared while the window stays open.
- R4: Each accepted sector-erase command restarts the timer, duplicates included. When WIN_CYC clock edges pass after the last accepted one without another, the block does the following in the cycle after that edge: `win_open` falls, `erase_busy` rises and `erase_start` pulses for exactly one cycle with the batch on `erase_map`.
- R5: While the window is open, a valid command whose kind has bit 1 set (2'b10 or 2'b11) raises `abort_pulse` for one cycle. It also closes the window and clears `erase_map`, and no erase start follows.
- R6: While the window is open, a command of kind 2'b01 (erase suspend) raises `suspend_fwd` for one cycle. It keeps `erase_map` unchanged and does not restart the timer.
- R7: A sector-erase command whose sector number is NUM_SECT or more has no effect: it does not open a window, mark a bit or restart the timer.
- R8: While `erase_busy` is 1, all commands are ignored and `erase_map` holds. A cycle with `erase_done` high returns the block to idle, with `erase_busy` 0 and `erase_map` cleared.
- R9: In idle, suspend and foreign commands are ignored. No window opens and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_kind | input | 2 | 00 sector erase, 01 erase suspend, 1x any other command |
| cmd_sector | input | SW | Sector number for sector erase |
| erase_done | input | 1 | Erase engine has finished the batch |
| win_open | output | 1 | Accumulation window is open |
| erase_busy | output | 1 | Status bit: 0 while window open or idle, 1 once erasure has started |
| erase_start | output | 1 | One-cycle pulse handing the batch to the erase engine |
| erase_map | output | NUM_SECT | Bitmap of selected sectors |
| abort_pulse | output | 1 | One-cycle pulse when a foreign command cancels the batch |
| suspend_fwd | output | 1 | One-cycle pulse forwarding an erase suspend received in the window |

## Verification
The main batch is built from out-of-order sector numbers, the lowest and highest sectors, a duplicate and an out-of-range number. This shows that set bits accumulate, that a repeat changes nothing and that an invalid sector is not accepted. A chain of requests spaced just inside the window separates a timer that restarts from one that runs from the first request. A suspend placed mid-window shows that suspend neither clears the map nor restarts the timer. Foreign commands are sent in idle, in the window and during erasure, which separates the abort path from the cases where commands are simply ignored.

// File: rtl/sector_erase_batcher.sv
module sector_erase_batcher #(
  parameter int NUM_SECT = 35,
  parameter int WIN_CYC  = 10000,
  localparam int SW = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1,
  localparam int CW = $clog2(WIN_CYC + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_kind,
  input  logic [SW-1:0]       cmd_sector,
  input  logic                erase_done,
  output logic                win_open,
  output logic                erase_busy,
  output logic                erase_start,
  output logic [NUM_SECT-1:0] erase_map,
  output logic                abort_pulse,
  output logic                suspend_fwd
);

  typedef enum logic [1:0] {S_IDLE, S_WIN, S_ERASE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;

  wire in_range = 32'(cmd_sector) < NUM_SECT;
  wire se_hit   = cmd_valid && (cmd_kind == 2'b00) && in_range;
  wire sus_hit  = cmd_valid && (cmd_kind == 2'b01);
  wire foreign  = cmd_valid && cmd_kind[1];
  wire expired  = (cnt == CW'(WIN_CYC - 1));
  wire [NUM_SECT-1:0] sel = NUM_SECT'(1) << cmd_sector;

  assign win_open   = (st == S_WIN);
  assign erase_busy = (st == S_ERASE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      erase_map   <= '0;
      erase_start <= 1'b0;
      abort_pulse <= 1'b0;
      suspend_fwd <= 1'b0;
    end else begin
      erase_start <= 1'b0;
      abort_pulse <= 1'b0;
      suspend_fwd <= 1'b0;
      case (st)
        S_IDLE: if (se_hit) begin
          st        <= S_WIN;
          cnt       <= '0;
          erase_map <= sel;
        end
        S_WIN: begin
          if (foreign) begin
            st          <= S_IDLE;
            cnt         <= '0;
            erase_map   <= '0;
            abort_pulse <= 1'b1;
          end else if (se_hit) begin
            erase_map <= erase_map | sel;
            cnt       <= '0;
          end else if (expired) begin
            st          <= S_ERASE;
            cnt         <= '0;
            erase_start <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
          if (sus_hit) suspend_fwd <= 1'b1;
        end
        S_ERASE: if (erase_done) begin
          st        <= S_IDLE;
          erase_map <= '0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!win_open && !erase_busy && erase_map == '0 && !erase_start));

  p_open_marks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_open) |-> $countones(erase_map) == 1);

  p_map_grows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open && $past(win_open)) |-> (($past(erase_map) & ~erase_map) == '0));

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> (cnt < CW'(WIN_CYC)));

  p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> (erase_busy && erase_map != '0 && $past(win_open)));

  p_abort_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> (!win_open && !erase_busy && erase_map == '0 && !erase_start));

  p_suspend_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_fwd |-> (erase_map == $past(erase_map) && erase_map != '0));

  p_erase_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_busy && $past(erase_busy)) |-> $stable(erase_map));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_open && !erase_busy) |-> (erase_map == '0 && !suspend_fwd && !erase_start));

endmodule

// File: tb/sector_erase_batcher_tb.sv
`timescale 1ns/1ps
module sector_erase_batcher_tb;
  localparam int NS = 35;
  localparam int W  = 12;
  localparam int SW = $clog2(NS);
  localparam logic [1:0] K_SE = 2'b00, K_SUS = 2'b01, K_OTH = 2'b10, K_OTH2 = 2'b11;
  localparam logic [1:0] EV_START = 2'd0, EV_ABORT = 2'd1, EV_SUS = 2'd2;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, erase_done = 0;
  logic [1:0] cmd_kind = 0;
  logic [SW-1:0] cmd_sector = 0;
  logic win_open, erase_busy, erase_start, abort_pulse, suspend_fwd;
  logic [NS-1:0] erase_map;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [NS+1:0] expq[$];

  always #2.5 clk = ~clk;

  sector_erase_batcher #(.NUM_SECT(NS), .WIN_CYC(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_sector(cmd_sector), .erase_done(erase_done), .win_open(win_open),
    .erase_busy(erase_busy), .erase_start(erase_start), .erase_map(erase_map),
    .abort_pulse(abort_pulse), .suspend_fwd(suspend_fwd));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] k, input int s);
    cmd_valid = 1; cmd_kind = k; cmd_sector = SW'(s);
    @(negedge clk);
    cmd_valid = 0; cmd_kind = 0; cmd_sector = 0;
  endtask

  task automatic finish_erase();
    erase_done = 1;
    @(negedge clk);
    erase_done = 0;
  endtask

  task automatic expect_ev(input logic [1:0] k, input logic [NS-1:0] m);
    expq.push_back({k, m});
  endtask

  function automatic logic [NS-1:0] bit_of(input int s);
    return NS'(1) << s;
  endfunction

  always @(negedge clk) begin
    if (rst_n && (erase_start || abort_pulse || suspend_fwd)) begin
      logic [1:0] k;
      logic [NS+1:0] e;
      k = erase_start ? EV_START : abort_pulse ? EV_ABORT : EV_SUS;
      if (expq.size() == 0) begin
        chk(0, "R4/R5/R6 unexpected event", 64'({k, erase_map}), 64'hffff);
      end else begin
        e = expq.pop_front();
        chk(e == {k, erase_map}, "R4/R5/R6 event", 64'({k, erase_map}), 64'(e));
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NS-1:0] m;
    repeat (3) @(negedge clk);
    chk(!win_open && !erase_busy && erase_map == 0 && !erase_start && !abort_pulse && !suspend_fwd,
        "R1 reset", 64'({win_open, erase_busy, erase_map}), 0);
    rst_n = 1;
    @(negedge clk);

    send(K_OTH, 3); send(K_SUS, 3); send(K_OTH2, 0);
    chk(!win_open && erase_map == 0, "R9 idle ignore", 64'({win_open, erase_map}), 0);
    send(K_SE, 40);
    chk(!win_open && erase_map == 0, "R7 oor idle", 64'({win_open, erase_map}), 0);

    send(K_SE, 5);
    chk(win_open && erase_map == bit_of(5), "R2 open", 64'({win_open, erase_map}), 64'({1'b1, bit_of(5)}));
    send(K_SE, 34); send(K_SE, 0);
    m = bit_of(5) | bit_of(34) | bit_of(0);
    chk(erase_map == m, "R3 accumulate", 64'(erase_map), 64'(m));
    send(K_SE, 50);
    chk(erase_map == m, "R7 oor window", 64'(erase_map), 64'(m));
    expect_ev(EV_START, m);
    send(K_SE, 5);
    chk(erase_map == m, "R3 duplicate", 64'(erase_map), 64'(m));
    repeat (W - 1) @(negedge clk);
    chk(win_open && !erase_busy, "R4 still open", 64'({win_open, erase_busy}), 64'b10);
    @(negedge clk);
    chk(!win_open && erase_busy && erase_start, "R4 start", 64'({win_open, erase_busy, erase_start}), 64'b011);
    @(negedge clk);
    chk(!erase_start && erase_busy, "R4 pulse one cycle", 64'({erase_start, erase_busy}), 64'b01);

    send(K_SE, 3); send(K_OTH, 0);
    chk(erase_busy && erase_map == m && !abort_pulse, "R8 ignore in erase", 64'(erase_map), 64'(m));
    finish_erase();
    chk(!erase_busy && erase_map == 0 && !win_open, "R8 done", 64'({erase_busy, erase_map}), 0);

    send(K_SE, 10);
    for (int i = 0; i < 3; i++) begin
      repeat (W - 3) @(negedge clk);
      send(K_SE, 11 + i);
    end
    chk(win_open, "R4 restart keeps window", 64'(win_open), 1);
    m = bit_of(10) | bit_of(11) | bit_of(12) | bit_of(13);
    expect_ev(EV_START, m);
    repeat (W) @(negedge clk);
    chk(erase_busy, "R4 restart expiry", 64'(erase_busy), 1);
    finish_erase();

    send(K_SE, 7); send(K_SE, 8);
    expect_ev(EV_ABORT, '0);
    send(K_OTH2, 1);
    chk(!win_open && erase_map == 0 && !erase_busy, "R5 abort", 64'({win_open, erase_map}), 0);
    repeat (W + 3) @(negedge clk);
    chk(!erase_busy && !win_open, "R5 no erase after abort", 64'(erase_busy), 0);
    send(K_SE, 20);
    expect_ev(EV_ABORT, '0);
    send(K_OTH, 20);
    chk(erase_map == 0, "R5 abort kind 10", 64'(erase_map), 0);

    send(K_SE, 2);
    repeat (3) @(negedge clk);
    expect_ev(EV_SUS, bit_of(2));
    send(K_SUS, 9);
    chk(win_open && erase_map == bit_of(2), "R6 suspend keeps map", 64'(erase_map), 64'(bit_of(2)));
    expect_ev(EV_START, bit_of(2));
    repeat (W - 5) @(negedge clk);
    chk(win_open && !erase_busy, "R6 before expiry", 64'(win_open), 1);
    @(negedge clk);
    chk(erase_busy, "R6 no restart", 64'(erase_busy), 1);
    finish_erase();

    repeat (2) @(negedge clk);
    chk(expq.size() == 0, "R4/R5/R6 all events seen", 64'(expq.size()), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule